// File: doc/BRIEF.md
# 24-bit program counter sequencer

This block generates the instruction fetch address for a microcontroller whose code space is 24 bits wide. The space is split into 64-Kbyte regions: the upper byte of an address is the region and the lower 16 bits are the offset. The block holds the program counter and moves it at each instruction boundary. The decoder signals a boundary with `step_i` and describes the instruction that just completed. The counter can advance by the instruction length, load an absolute 24-bit jump target, take a signed 8-bit relative branch, or enter a vector. Every target is formed as a full 24-bit value, so relative branches cross region boundaries in both directions. Absolute jumps take their region byte only from the operand, so a carry from the length increment never reaches it.

A small state machine controls the counter. It has three states:
- `ST_BOOT` is held during reset and for one cycle after it. The counter sits at the reset vector FF:0000 and boundary strobes are ignored.
- `ST_RUN` is normal sequencing. A boundary strobe with `irq_i` high accepts the interrupt (transition RUN→ENTRY). A strobe without an interrupt stays in RUN (RUN→RUN).
- `ST_ENTRY` lasts until the first boundary after an interrupt vector. That boundary follows its operation code but does not accept a new interrupt (transition ENTRY→RUN).

BOOT always moves to RUN one cycle after reset is released. On acceptance, the address where execution would have resumed is presented on `ret_addr_o` so that an external stack can save it. The `vec_local_i` configuration bit selects where vectors are placed. When it is clear, vectors land in the top region FF:, whatever region is running. When it is set, vectors land in the region currently executing.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high and during the first cycle after it falls, `fetch_addr_o` is FF:0000, `ret_addr_o` is 0 and `irq_ack_o` is 0. A strobe in that first cycle after reset has no effect.
- R2: Operation code 2'b00 (sequential) sets the counter to PC + `len_i` (1 to 5), computed modulo 2^24. An offset carry moves into the next region, and FF:FFFF wraps to 00:0000.
- R3: Operation code 2'b01 (extended jump) loads all 24 bits of `target_i`, whatever the current PC. A jump at FE:FFFD to 00:1234 lands at 00:1234.
- R4: Operation code 2'b10 (relative branch) sets the counter to PC + `len_i` + sign-extended `disp_i`, computed over the full 24 bits. The branch crosses FF:→FE:, FE:→FF:, 00:→01: and 01:→00:. For example, FF:0002 with length 2 and displacement 0xEC gives FE:FFF0.
- R5: Operation code 2'b11 (vector) jumps to the vector address formed from `vec_ofs_i`.
- R6: A vector address has offset {8'h00, `vec_ofs_i`}. Its region is FF when `vec_local_i` is 0, and the region of the current PC when `vec_local_i` is 1.
- R7: In RUN, a strobe with `irq_i` high loads the vector address. `ret_addr_o` receives the address the completed instruction would have gone to, and `irq_ack_o` is high for exactly the next cycle.
- R8: The first strobe after an acceptance follows its operation code and ignores `irq_i`.
- R9: Without a strobe, `fetch_addr_o` holds its value and no interrupt is accepted.
- R10: `ret_addr_o` changes only on an interrupt acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Instruction boundary strobe |
| op_i | input | 2 | Operation code of the completed instruction |
| len_i | input | 3 | Instruction length in bytes |
| target_i | input | 24 | Absolute jump target |
| disp_i | input | 8 | Signed relative displacement |
| irq_i | input | 1 | Interrupt request |
| vec_ofs_i | input | 8 | Vector offset within the vector region |
| vec_local_i | input | 1 | Vector placement: 0 = top region, 1 = current region |
| fetch_addr_o | output | 24 | Current fetch address |
| ret_addr_o | output | 24 | Return address captured at interrupt acceptance |
| irq_ack_o | output | 1 | One-cycle pulse after an interrupt is accepted |

## Verification
A wrong next-address computation appears on `fetch_addr_o` one cycle after the offending strobe. The bench checks every cycle, so the error is caught at once. The likely faults are a region byte taken from the wrong source, or an addition narrowed to 16 bits. A state machine stuck in the wrong state shows up within one boundary: a missing or repeated `irq_ack_o`, a strobe ignored after reset, or an interrupt accepted twice in a row. A corrupted return register is seen the cycle after acceptance and at every later compare, because its value must hold.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    typedef enum logic [1:0] {
        OP_SEQ    = 2'b00,
        OP_XJMP   = 2'b01,
        OP_BRANCH = 2'b10,
        OP_TRAP   = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'b00,
        ST_RUN   = 2'b01,
        ST_ENTRY = 2'b10
    } seq_state_e;

endpackage

// File: rtl/pc_next_calc.sv
module pc_next_calc
    import pc_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned LEN_W  = 3,
    parameter int unsigned DISP_W = 8
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  op_e               op_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [ADDR_W-1:0] vec_addr_i,
    output logic [ADDR_W-1:0] next_o
);
    localparam int unsigned EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] rel_addr;

    // Full-width arithmetic: region byte carries and borrows naturally.
    assign seq_addr = pc_i + ADDR_W'(len_i);
    assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    assign rel_addr = seq_addr + disp_ext;

    // Absolute target bypasses the incrementer entirely.
    always_comb begin
        unique case (op_i)
            OP_SEQ:    next_o = seq_addr;
            OP_XJMP:   next_o = target_i;
            OP_BRANCH: next_o = rel_addr;
            OP_TRAP:   next_o = vec_addr_i;
            default:   next_o = seq_addr;
        endcase
    end
endmodule

// File: rtl/pc_vector_gen.sv
module pc_vector_gen #(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned REGION_W   = 8,
    parameter int unsigned VOFS_W     = 8,
    parameter logic [REGION_W-1:0] TOP_REGION = '1
) (
    input  logic [REGION_W-1:0] cur_region_i,
    input  logic                vec_local_i,
    input  logic [VOFS_W-1:0]   vec_ofs_i,
    output logic [ADDR_W-1:0]   vec_addr_o
);
    localparam int unsigned OFS_W = ADDR_W - REGION_W;
    localparam int unsigned PAD_W = OFS_W - VOFS_W;

    logic [REGION_W-1:0] region_sel;
    logic [OFS_W-1:0]    ofs_full;

    assign region_sel = vec_local_i ? cur_region_i : TOP_REGION;

    generate
        if (PAD_W > 0) begin : g_pad
            assign ofs_full = {{PAD_W{1'b0}}, vec_ofs_i};
        end else begin : g_nopad
            assign ofs_full = vec_ofs_i[OFS_W-1:0];
        end
    endgenerate

    assign vec_addr_o = {region_sel, ofs_full};
endmodule

// File: rtl/pc_seq_fsm.sv
module pc_seq_fsm
    import pc_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic              irq_i,
    input  logic [ADDR_W-1:0] next_i,
    input  logic [ADDR_W-1:0] vec_addr_i,
    output seq_state_e        state_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] ret_o,
    output logic              ack_o
);
    seq_state_e state_q, state_d;
    logic       take_irq;

    assign take_irq = (state_q == ST_RUN) && step_i && irq_i;
    assign state_o  = state_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_BOOT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_RUN;
            ST_RUN:   state_d = take_irq ? ST_ENTRY : ST_RUN;
            ST_ENTRY: state_d = step_i ? ST_RUN : ST_ENTRY;
            default:  state_d = ST_BOOT;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_o  <= RESET_ADDR;
            ret_o <= '0;
            ack_o <= 1'b0;
        end else begin
            ack_o <= take_irq;
            unique case (state_q)
                ST_BOOT: ;
                ST_RUN: begin
                    if (step_i) begin
                        if (irq_i) begin
                            pc_o  <= vec_addr_i;
                            ret_o <= next_i;
                        end else begin
                            pc_o <= next_i;
                        end
                    end
                end
                ST_ENTRY: begin
                    if (step_i) pc_o <= next_i;
                end
                default: ;
            endcase
        end
    end

    assert_boot_vector_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BOOT) |-> (pc_o == RESET_ADDR && ret_o == '0 && !ack_o));

    assert_ack_enters_R7: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (state_q == ST_ENTRY));

    assert_no_nested_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ENTRY) |=> !ack_o);

    assert_hold_pc_R9: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(pc_o));

    assert_ret_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !ack_o |-> (ret_o == $past(ret_o)) || $past(rst));
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned REGION_W = 8,
    parameter int unsigned LEN_W    = 3,
    parameter int unsigned DISP_W   = 8,
    parameter int unsigned VOFS_W   = 8,
    parameter logic [REGION_W-1:0] TOP_REGION = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic [1:0]        op_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              irq_i,
    input  logic [VOFS_W-1:0] vec_ofs_i,
    input  logic              vec_local_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic [ADDR_W-1:0] ret_addr_o,
    output logic              irq_ack_o
);
    localparam int unsigned OFS_W = ADDR_W - REGION_W;
    localparam logic [ADDR_W-1:0] RESET_ADDR = {TOP_REGION, {OFS_W{1'b0}}};

    op_e               op;
    seq_state_e        state;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] vec_addr;
    logic [ADDR_W-1:0] next_addr;

    assign op = op_e'(op_i);

    pc_vector_gen #(
        .ADDR_W(ADDR_W), .REGION_W(REGION_W), .VOFS_W(VOFS_W), .TOP_REGION(TOP_REGION)
    ) u_vec (
        .cur_region_i(pc[ADDR_W-1 -: REGION_W]),
        .vec_local_i (vec_local_i),
        .vec_ofs_i   (vec_ofs_i),
        .vec_addr_o  (vec_addr)
    );

    pc_next_calc #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DISP_W(DISP_W)
    ) u_next (
        .pc_i      (pc),
        .op_i      (op),
        .len_i     (len_i),
        .target_i  (target_i),
        .disp_i    (disp_i),
        .vec_addr_i(vec_addr),
        .next_o    (next_addr)
    );

    pc_seq_fsm #(
        .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .step_i    (step_i),
        .irq_i     (irq_i),
        .next_i    (next_addr),
        .vec_addr_i(vec_addr),
        .state_o   (state),
        .pc_o      (pc),
        .ret_o     (ret_addr_o),
        .ack_o     (irq_ack_o)
    );

    assign fetch_addr_o = pc;

    // Port-level checks of the address arithmetic
    logic              normal_step;
    logic [ADDR_W-1:0] len_ext;
    logic [ADDR_W-1:0] disp_ext;

    assign normal_step = step_i && (state != ST_BOOT) && !(state == ST_RUN && irq_i);
    assign len_ext     = ADDR_W'(len_i);
    assign disp_ext    = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};

    assert_seq_add_R2: assert property (@(posedge clk) disable iff (rst)
        (normal_step && op_i == 2'b00) |=> (fetch_addr_o - $past(fetch_addr_o)) == $past(len_ext));

    assert_xjmp_target_R3: assert property (@(posedge clk) disable iff (rst)
        (normal_step && op_i == 2'b01) |=> fetch_addr_o == $past(target_i));

    assert_branch_span_R4: assert property (@(posedge clk) disable iff (rst)
        (normal_step && op_i == 2'b10) |=>
            (fetch_addr_o - $past(fetch_addr_o)) == ($past(len_ext) + $past(disp_ext)));

    assert_vector_place_R6: assert property (@(posedge clk) disable iff (rst)
        (step_i && state == ST_RUN && irq_i && !vec_local_i) |=>
            fetch_addr_o == {TOP_REGION, {(OFS_W-VOFS_W){1'b0}}, $past(vec_ofs_i)});
endmodule

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [2:0]  len_i = 3'd1;
    logic [23:0] target_i = '0;
    logic [7:0]  disp_i = '0;
    logic        irq_i = 1'b0;
    logic [7:0]  vec_ofs_i = '0;
    logic        vec_local_i = 1'b0;
    logic [23:0] fetch_addr_o;
    logic [23:0] ret_addr_o;
    logic        irq_ack_o;

    always #5 clk = ~clk;

    pc_sequencer dut (
        .clk(clk), .rst(rst), .step_i(step_i), .op_i(op_i), .len_i(len_i),
        .target_i(target_i), .disp_i(disp_i), .irq_i(irq_i), .vec_ofs_i(vec_ofs_i),
        .vec_local_i(vec_local_i), .fetch_addr_o(fetch_addr_o),
        .ret_addr_o(ret_addr_o), .irq_ack_o(irq_ack_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    // model state: 0 boot, 1 run, 2 entry
    int          m_st  = 0;
    logic [23:0] m_pc  = 24'hFF0000;
    logic [23:0] m_ret = '0;
    logic        m_ack = 1'b0;

    function automatic logic [23:0] f_vec(logic [23:0] pc, logic [7:0] ofs, logic loc);
        return {(loc ? pc[23:16] : 8'hFF), 8'h00, ofs};
    endfunction

    function automatic logic [23:0] f_next(logic [23:0] pc, logic [1:0] op, logic [2:0] len,
                                           logic [23:0] tgt, logic [7:0] d, logic [23:0] v);
        logic [23:0] s;
        s = pc + {21'd0, len};
        case (op)
            2'b00:   return s;
            2'b01:   return tgt;
            2'b10:   return s + {{16{d[7]}}, d};
            default: return v;
        endcase
    endfunction

    task automatic chk24(string req, string what, logic [23:0] act, logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%06h expected=%06h", req, what, act, exp);
        end
    endtask

    task automatic chk1(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Called at a negative edge; returns at the next negative edge after comparing.
    task automatic apply(string req, logic st, logic [1:0] op, logic [2:0] len,
                         logic [23:0] tgt, logic [7:0] d, logic irq,
                         logic [7:0] vo, logic vl);
        logic [23:0] v, nx;
        step_i = st; op_i = op; len_i = len; target_i = tgt; disp_i = d;
        irq_i = irq; vec_ofs_i = vo; vec_local_i = vl;
        v  = f_vec(m_pc, vo, vl);
        nx = f_next(m_pc, op, len, tgt, d, v);
        m_ack = 1'b0;
        case (m_st)
            0: m_st = 1;
            1: if (st) begin
                   if (irq) begin
                       m_ret = nx; m_pc = v; m_ack = 1'b1; m_st = 2;
                   end else m_pc = nx;
               end
            default: if (st) begin m_pc = nx; m_st = 1; end
        endcase
        @(posedge clk);
        @(negedge clk);
        chk24(req, "fetch_addr", fetch_addr_o, m_pc);
        chk24(req, "ret_addr", ret_addr_o, m_ret);
        chk1(req, "irq_ack", irq_ack_o, m_ack);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5147));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk24("R1", "fetch_addr in reset", fetch_addr_o, 24'hFF0000);
        chk24("R1", "ret_addr in reset", ret_addr_o, 24'h0);
        chk1("R1", "irq_ack in reset", irq_ack_o, 1'b0);
        rst = 1'b0;
        // R1: strobe in boot cycle is ignored
        apply("R1", 1'b1, 2'b01, 3'd4, 24'h123456, 8'h0, 1'b1, 8'h03, 1'b0);
        // R3: extended jump from the end of region FE lands in region 00
        apply("R3", 1'b1, 2'b01, 3'd4, 24'hFEFFFD, 8'h0, 1'b0, 8'h0, 1'b0);
        apply("R3", 1'b1, 2'b01, 3'd4, 24'h001234, 8'h0, 1'b0, 8'h0, 1'b0);
        // R4: FF:0002 back to FE:FFF0, then forward to FF:0002
        apply("R4", 1'b1, 2'b01, 3'd4, 24'hFF0002, 8'h0, 1'b0, 8'h0, 1'b0);
        apply("R4", 1'b1, 2'b10, 3'd2, 24'h0, 8'hEC, 1'b0, 8'h0, 1'b0);
        apply("R4", 1'b1, 2'b10, 3'd2, 24'h0, 8'h10, 1'b0, 8'h0, 1'b0);
        // R4: 00 <-> 01 crossings
        apply("R4", 1'b1, 2'b01, 3'd4, 24'h00FFF0, 8'h0, 1'b0, 8'h0, 1'b0);
        apply("R4", 1'b1, 2'b10, 3'd2, 24'h0, 8'h20, 1'b0, 8'h0, 1'b0);
        apply("R4", 1'b1, 2'b10, 3'd2, 24'h0, 8'hE0, 1'b0, 8'h0, 1'b0);
        // R2: region carry and top wrap
        apply("R2", 1'b1, 2'b01, 3'd4, 24'h00FFFF, 8'h0, 1'b0, 8'h0, 1'b0);
        apply("R2", 1'b1, 2'b00, 3'd1, 24'h0, 8'h0, 1'b0, 8'h0, 1'b0);
        apply("R2", 1'b1, 2'b01, 3'd4, 24'hFFFFFE, 8'h0, 1'b0, 8'h0, 1'b0);
        apply("R2", 1'b1, 2'b00, 3'd3, 24'h0, 8'h0, 1'b0, 8'h0, 1'b0);
        // R7/R6: interrupt from region FE goes to FF:0003
        apply("R7", 1'b1, 2'b01, 3'd4, 24'hFE1000, 8'h0, 1'b0, 8'h0, 1'b0);
        apply("R7", 1'b1, 2'b00, 3'd2, 24'h0, 8'h0, 1'b1, 8'h03, 1'b0);
        // R8: next boundary ignores interrupt
        apply("R8", 1'b1, 2'b00, 3'd3, 24'h0, 8'h0, 1'b1, 8'h0B, 1'b0);
        // R10: return address holds
        apply("R10", 1'b1, 2'b00, 3'd1, 24'h0, 8'h0, 1'b0, 8'h0, 1'b0);
        // R6: local placement in region 05
        apply("R6", 1'b1, 2'b01, 3'd4, 24'h057777, 8'h0, 1'b0, 8'h0, 1'b0);
        apply("R6", 1'b1, 2'b10, 3'd2, 24'h0, 8'h05, 1'b1, 8'h13, 1'b1);
        // R9: no strobe, irq high: nothing happens
        apply("R9", 1'b0, 2'b01, 3'd4, 24'h000000, 8'h0, 1'b1, 8'h03, 1'b0);
        apply("R9", 1'b0, 2'b00, 3'd5, 24'h0, 8'h0, 1'b1, 8'h03, 1'b0);
        // R5: vector operation code, both placements
        apply("R5", 1'b1, 2'b11, 3'd1, 24'h0, 8'h0, 1'b0, 8'h2B, 1'b0);
        apply("R5", 1'b1, 2'b01, 3'd4, 24'h3A0100, 8'h0, 1'b0, 8'h0, 1'b0);
        apply("R5", 1'b1, 2'b11, 3'd1, 24'h0, 8'h0, 1'b0, 8'h33, 1'b1);
        // Random stimulus
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] op;
            logic       irq, st;
            string      tag;
            op  = 2'($urandom_range(0, 3));
            irq = ($urandom_range(0, 7) == 0);
            st  = ($urandom_range(0, 4) != 0);
            if (!st) tag = "R9";
            else if (irq && m_st == 1) tag = "R7";
            else if (irq) tag = "R8";
            else if (op == 2'b00) tag = "R2";
            else if (op == 2'b01) tag = "R3";
            else if (op == 2'b10) tag = "R4";
            else tag = "R5";
            apply(tag, st, op, 3'($urandom_range(1, 5)), 24'($urandom),
                  8'($urandom), irq, 8'($urandom), 1'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule